// File: doc/BRIEF.md
# CEC Receive Header Filter and Acknowledge Control

This block sits behind the bit-level receiver of a consumer-electronics control bus node. It takes a stream of assembled bytes, treats the first byte of each frame as the header, and decides from the destination field whether the frame belongs in the receive buffer and whether this node pulls the line during the acknowledge slot that follows each byte. The node can answer several logical addresses at once, because its own address is given as a bitmap rather than a single code.

Two listening modes are supported. The reduced mode keeps only frames for one of the node's addresses plus broadcast frames. The full mode also captures frames sent to other nodes, but stays silent in their acknowledge slots. Accepted bytes are handed out one at a time with a pulse and a held data value. A byte that arrives before the consumer has taken the previous one is dropped and flagged as an overrun. Each accepted frame ends with a pulse that reports how many payload bytes followed the header.

Top module: `cec_rx_addr_filter`

## Requirements
- R1: The destination of a frame is header bits 3:0 (the initiator is bits 7:4 and is not used for filtering); when destination k (0..14) has bit k of `own_map` set, the frame is accepted (`frame_accept`=1) and a positive acknowledge is driven.
- R2: A header with destination 15 is a broadcast: it is accepted in both listening modes and `ack_drive` stays 0 in all its acknowledge slots.
- R3: In reduced mode (`full_listen`=0) a frame for a destination whose `own_map` bit is clear is ignored: `frame_accept`=0 and no byte pulse, end pulse or acknowledge is produced for any of its bytes.
- R4: In full mode (`full_listen`=1) a frame for another destination is accepted and every byte is delivered, but `ack_drive` stays 0.
- R5: Every delivered byte, header included, raises `rx_byte_pulse` for exactly the one cycle after the clock edge that captured it, with the byte on `rx_byte_data`, which then holds until the next delivered byte.
- R6: `ack_drive` is high only during `ack_slot`, and only for the first acknowledge slot after an acknowledged byte; a second slot with no byte in between is not driven.
- R7: A byte meant for delivery that arrives while the previous one is still pending (no `rx_taken` since its pulse, and none in the same cycle) is discarded (no pulse, `rx_byte_data` unchanged) and sets `overrun`; `overrun` stays set until the next header, which clears it.
- R8: After the capturing edge of the byte marked `byte_last` of an accepted frame, `eor_pulse` is high for one cycle with `eor_count` equal to the number of payload bytes that followed the header, overrun bytes included; a header-only frame reports 0.
- R9: A frame carries at most 15 payload bytes; further payload bytes are not delivered, do not cause overrun, and `eor_count` saturates at 15.
- R10: `own_map` and `full_listen` are sampled only at the header; changing them inside a frame does not alter its acceptance or acknowledge.
- R11: After reset `frame_accept`, `ack_drive`, `rx_byte_pulse`, `eor_pulse`, `overrun`, `rx_byte_data` and `eor_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | One-cycle strobe: a whole byte has been received |
| byte_data | input | 8 | The received byte |
| byte_last | input | 1 | Qualifies `byte_valid`: this byte ends the frame |
| rx_taken | input | 1 | Consumer has taken the pending byte |
| ack_slot | input | 1 | High while the acknowledge slot after a byte is open; never coincides with `byte_valid` |
| own_map | input | 15 | Own-address bitmap, bit k answers logical address k |
| full_listen | input | 1 | 1: full listening mode, 0: reduced mode |
| frame_accept | output | 1 | Acceptance decision of the current or most recent frame |
| ack_drive | output | 1 | Pull the bus low in this acknowledge slot |
| rx_byte_pulse | output | 1 | One-cycle pulse: a byte is delivered |
| rx_byte_data | output | 8 | Last delivered byte |
| eor_pulse | output | 1 | One-cycle pulse at the end of an accepted frame |
| eor_count | output | 4 | Payload byte count reported with `eor_pulse` |
| overrun | output | 1 | A byte was lost since the last header |

## Verification
Directed frames cover a single own address, a bitmap with several addresses set, broadcast in both modes, foreign destinations in both modes and a header-only ping; together they separate the accept decision from the acknowledge decision, which differ only for broadcast and full-mode foreign traffic. Dedicated sequences hold back `rx_taken` to force a lost byte, send more than fifteen payload bytes, issue two acknowledge slots after one byte, and alter the bitmap and mode in mid-frame. Random frames then mix destinations, bitmaps, modes, lengths up to seventeen payload bytes and occasional unserviced bytes, all compared byte by byte against a bench model built from the requirements.

// File: rtl/cec_filt_pkg.sv
package cec_filt_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 4;
    // logical addresses that can be owned; the all-ones code is broadcast
    localparam int unsigned N_ADDR = (1 << ADDR_W) - 1;
    localparam logic [ADDR_W-1:0] BCAST_ADDR = ADDR_W'(N_ADDR);

    typedef struct packed {
        logic own_hit;  // destination is one of this node's addresses
        logic bcast;    // destination is the broadcast code
        logic accept;   // frame goes to the receive buffer
        logic ack;      // node drives positive acknowledge
    } hdr_dec_t;

endpackage

// File: rtl/cec_hdr_decode.sv
module cec_hdr_decode
    import cec_filt_pkg::*;
(
    input  logic [BYTE_W-1:0] hdr_byte,
    input  logic [N_ADDR-1:0] own_map,
    input  logic              full_listen,
    output hdr_dec_t          dec
);
    logic [ADDR_W-1:0] dest;
    logic [N_ADDR-1:0] slot_hit;

    assign dest = hdr_byte[ADDR_W-1:0];

    // one comparator per ownable logical address
    for (genvar k = 0; k < N_ADDR; k++) begin : g_addr
        assign slot_hit[k] = own_map[k] && (dest == ADDR_W'(k));
    end

    always_comb begin
        dec.own_hit = |slot_hit;
        dec.bcast   = (dest == BCAST_ADDR);
        dec.accept  = dec.own_hit || dec.bcast || full_listen;
        // broadcast acknowledge is inverted: stay passive
        dec.ack     = dec.own_hit;
    end

endmodule

// File: rtl/cec_frame_track.sv
module cec_frame_track
    import cec_filt_pkg::*;
#(
    parameter int unsigned MAX_PAYLOAD = 15,
    localparam int unsigned CNT_W = $clog2(MAX_PAYLOAD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic             byte_last,
    input  logic             ack_slot,
    input  hdr_dec_t         dec,
    output logic             is_hdr,
    output logic             byte_take,
    output logic             frame_accept,
    output logic             ack_drive,
    output logic             eor_pulse,
    output logic [CNT_W-1:0] eor_count
);
    typedef struct packed {
        logic             in_frame;
        logic             accept;
        logic             bcast;
        logic             ack_en;
        logic             ack_win;
        logic [CNT_W-1:0] cnt;
        logic             eor;
        logic [CNT_W-1:0] eor_cnt;
    } trk_t;

    trk_t st_d, st_q;
    logic             cnt_full;
    logic [CNT_W-1:0] cnt_inc;

    assign is_hdr   = !st_q.in_frame;
    assign cnt_full = (st_q.cnt == CNT_W'(MAX_PAYLOAD));
    assign cnt_inc  = cnt_full ? st_q.cnt : st_q.cnt + CNT_W'(1);

    always_comb begin
        st_d     = st_q;
        st_d.eor = 1'b0;
        byte_take = 1'b0;
        if (byte_valid && is_hdr) begin
            st_d.accept   = dec.accept;
            st_d.bcast    = dec.bcast;
            st_d.ack_en   = dec.ack;
            st_d.ack_win  = dec.ack;
            st_d.cnt      = '0;
            st_d.in_frame = !byte_last;
            st_d.eor      = byte_last && dec.accept;
            st_d.eor_cnt  = byte_last ? '0 : st_q.eor_cnt;
            byte_take     = dec.accept;
        end else if (byte_valid) begin
            st_d.cnt      = cnt_inc;
            st_d.ack_win  = st_q.ack_en;
            st_d.in_frame = !byte_last;
            st_d.eor      = byte_last && st_q.accept;
            st_d.eor_cnt  = byte_last ? cnt_inc : st_q.eor_cnt;
            byte_take     = st_q.accept && !cnt_full;
        end else if (ack_slot) begin
            st_d.ack_win  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_accept = st_q.accept;
    assign ack_drive    = ack_slot && st_q.ack_win;
    assign eor_pulse    = st_q.eor;
    assign eor_count    = st_q.eor_cnt;

    p_bcast_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive |-> !st_q.bcast);

    p_ack_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive |=> (!ack_drive || $past(byte_valid)));

    p_ping_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eor_pulse |-> ((eor_count == '0) == $past(is_hdr)));

    p_count_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !is_hdr && cnt_full) |-> !byte_take);

endmodule

// File: rtl/cec_byte_deliver.sv
module cec_byte_deliver
    import cec_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              is_hdr,
    input  logic              byte_take,
    input  logic              rx_taken,
    input  logic              frame_accept,
    output logic              rx_byte_pulse,
    output logic [BYTE_W-1:0] rx_byte_data,
    output logic              overrun
);
    typedef struct packed {
        logic              pending;
        logic              pulse;
        logic [BYTE_W-1:0] data;
        logic              ovr;
    } dlv_t;

    dlv_t st_d, st_q;
    logic lost, store;

    assign lost  = byte_take && st_q.pending && !rx_taken;
    assign store = byte_take && !lost;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = store;
        if (store)         st_d.data = byte_data;
        if (store)         st_d.pending = 1'b1;
        else if (rx_taken) st_d.pending = 1'b0;
        if (byte_valid && is_hdr) st_d.ovr = lost;
        else                      st_d.ovr = st_q.ovr || lost;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_byte_pulse = st_q.pulse;
    assign rx_byte_data  = st_q.data;
    assign overrun       = st_q.ovr;

    p_reject_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_pulse |-> frame_accept);

    p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_pulse |-> $past(byte_valid));

    p_overrun_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> (!rx_byte_pulse && $stable(rx_byte_data)));

endmodule

// File: rtl/cec_rx_addr_filter.sv
module cec_rx_addr_filter
    import cec_filt_pkg::*;
#(
    parameter int unsigned MAX_PAYLOAD = 15,
    localparam int unsigned CNT_W = $clog2(MAX_PAYLOAD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_last,
    input  logic              rx_taken,
    input  logic              ack_slot,
    input  logic [N_ADDR-1:0] own_map,
    input  logic              full_listen,
    output logic              frame_accept,
    output logic              ack_drive,
    output logic              rx_byte_pulse,
    output logic [BYTE_W-1:0] rx_byte_data,
    output logic              eor_pulse,
    output logic [CNT_W-1:0]  eor_count,
    output logic              overrun
);
    hdr_dec_t dec;
    logic     is_hdr;
    logic     byte_take;

    cec_hdr_decode u_dec (
        .hdr_byte    (byte_data),
        .own_map     (own_map),
        .full_listen (full_listen),
        .dec         (dec)
    );

    cec_frame_track #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid   (byte_valid),
        .byte_last    (byte_last),
        .ack_slot     (ack_slot),
        .dec          (dec),
        .is_hdr       (is_hdr),
        .byte_take    (byte_take),
        .frame_accept (frame_accept),
        .ack_drive    (ack_drive),
        .eor_pulse    (eor_pulse),
        .eor_count    (eor_count)
    );

    cec_byte_deliver u_dlv (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_valid    (byte_valid),
        .byte_data     (byte_data),
        .is_hdr        (is_hdr),
        .byte_take     (byte_take),
        .rx_taken      (rx_taken),
        .frame_accept  (frame_accept),
        .rx_byte_pulse (rx_byte_pulse),
        .rx_byte_data  (rx_byte_data),
        .overrun       (overrun)
    );

    p_ack_in_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive |-> (ack_slot && !rx_byte_pulse || ack_slot));

    p_hdr_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && is_hdr && own_map[byte_data[3:0] == 4'hF ? 0 : byte_data[3:0]]
         && byte_data[3:0] != 4'hF) |=> frame_accept);

endmodule

// File: tb/cec_rx_addr_filter_bench.sv
`timescale 1ns/1ps
module cec_rx_addr_filter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        byte_last = 1'b0;
    logic        rx_taken = 1'b0;
    logic        ack_slot = 1'b0;
    logic [14:0] own_map = '0;
    logic        full_listen = 1'b0;
    logic        frame_accept, ack_drive, rx_byte_pulse, eor_pulse, overrun;
    logic [7:0]  rx_byte_data;
    logic [3:0]  eor_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state
    bit       m_in_frame = 0, m_accept = 0, m_acken = 0, m_pending = 0, m_ovr = 0;
    int       m_cnt = 0;
    logic [7:0] m_data = '0;

    always #4 clk = ~clk;

    cec_rx_addr_filter u_cec_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_last(byte_last), .rx_taken(rx_taken), .ack_slot(ack_slot),
        .own_map(own_map), .full_listen(full_listen), .frame_accept(frame_accept),
        .ack_drive(ack_drive), .rx_byte_pulse(rx_byte_pulse), .rx_byte_data(rx_byte_data),
        .eor_pulse(eor_pulse), .eor_count(eor_count), .overrun(overrun)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected decision from the header rules (R1..R4)
    function automatic bit exp_accept(input logic [7:0] h, input logic [14:0] map, input bit full);
        logic [3:0] d = h[3:0];
        if (d == 4'hF) return 1;
        return map[d] || full;
    endfunction

    function automatic bit exp_ack(input logic [7:0] h, input logic [14:0] map);
        logic [3:0] d = h[3:0];
        if (d == 4'hF) return 0;
        return map[d];
    endfunction

    task automatic send_byte(input logic [7:0] d, input bit last, input bit serve, input string req);
        bit take, lost, deliver, win, hdr;
        hdr = !m_in_frame;
        if (hdr) begin
            m_accept = exp_accept(d, own_map, full_listen);
            m_acken  = exp_ack(d, own_map);
            m_cnt    = 0;
            take     = m_accept;
        end else begin
            take = m_accept && (m_cnt < 15);
            if (m_cnt < 15) m_cnt++;
        end
        win = m_acken;
        m_in_frame = !last;
        lost = take && m_pending;
        deliver = take && !lost;
        if (deliver) begin m_pending = 1; m_data = d; end
        m_ovr = hdr ? lost : (m_ovr || lost);

        @(negedge clk);
        byte_valid = 1'b1; byte_data = d; byte_last = last;
        @(negedge clk);
        byte_valid = 1'b0; byte_last = 1'b0;
        check(req, "rx_byte_pulse", rx_byte_pulse, deliver);
        check(req, "rx_byte_data", rx_byte_data, m_data);
        check(req, "overrun", overrun, m_ovr);
        check(req, "frame_accept", frame_accept, m_accept);
        check(req, "eor_pulse", eor_pulse, last && m_accept);
        if (last && m_accept) check(req, "eor_count", eor_count, m_cnt);
        if (serve && m_pending) begin rx_taken = 1'b1; m_pending = 0; end
        ack_slot = 1'b1;
        #1 check(req, "ack_drive", ack_drive, win);
        @(negedge clk);
        rx_taken = 1'b0; ack_slot = 1'b0;
    endtask

    task automatic service();
        @(negedge clk);
        rx_taken = 1'b1; m_pending = 0;
        @(negedge clk);
        rx_taken = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] hdr, input int n, input string req);
        send_byte(hdr, n == 0, 1, req);
        for (int i = 0; i < n; i++)
            send_byte(8'(8'h30 + i), i == n - 1, 1, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C3C));
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "frame_accept", frame_accept, 0);
        check("R11", "ack_drive", ack_drive, 0);
        check("R11", "rx_byte_pulse", rx_byte_pulse, 0);
        check("R11", "eor_pulse", eor_pulse, 0);
        check("R11", "overrun", overrun, 0);
        check("R11", "rx_byte_data", rx_byte_data, 0);
        check("R11", "eor_count", eor_count, 0);
        rst_n = 1'b1;

        // R1: single own address, then a multi-address bitmap
        own_map = 15'h0010; full_listen = 0;
        send_frame(8'h34, 3, "R1");
        own_map = 15'h4201;
        send_frame(8'h50, 2, "R1");
        send_frame(8'h59, 1, "R1");
        send_frame(8'h5E, 1, "R1");
        // R2: broadcast in both modes
        send_frame(8'h4F, 2, "R2");
        full_listen = 1;
        send_frame(8'h4F, 1, "R2");
        // R4: foreign destination in full mode
        send_frame(8'h13, 2, "R4");
        // R3: foreign destination in reduced mode
        full_listen = 0;
        send_frame(8'h13, 3, "R3");
        // R8: ping to own and broadcast
        send_frame(8'h10, 0, "R8");
        send_frame(8'h1F, 0, "R8");
        // R5: consecutive delivered bytes with distinct data
        send_frame(8'h20, 4, "R5");
        // R6: second acknowledge slot without a byte is not driven
        send_byte(8'h20, 1, 1, "R6");
        @(negedge clk); ack_slot = 1'b1;
        #1 check("R6", "ack_drive second slot", ack_drive, 0);
        @(negedge clk); ack_slot = 1'b0;
        #1 check("R6", "ack_drive outside slot", ack_drive, 0);
        // R7: unserviced byte then another byte is lost
        send_byte(8'h20, 0, 0, "R7");
        send_byte(8'hA1, 0, 0, "R7");
        send_byte(8'hA2, 1, 0, "R7");
        service();
        send_byte(8'h20, 1, 1, "R7");
        // R9: seventeen payload bytes
        send_frame(8'h20, 17, "R9");
        // R10: settings changed inside a frame
        own_map = 15'h0004; full_listen = 0;
        send_byte(8'h02, 0, 1, "R10");
        own_map = 15'h0000; full_listen = 1;
        send_byte(8'h77, 0, 1, "R10");
        own_map = 15'h0000; full_listen = 0;
        send_byte(8'h78, 1, 1, "R10");
        own_map = 15'h0000; full_listen = 1;
        send_byte(8'h05, 0, 1, "R10");
        own_map = 15'h0020; full_listen = 0;
        send_byte(8'h06, 1, 1, "R10");

        // random frames
        for (int f = 0; f < 300; f++) begin
            int len;
            logic [7:0] h;
            own_map = 15'($urandom);
            if (($urandom % 4) == 0) own_map = '0;
            full_listen = 1'($urandom);
            h = 8'($urandom);
            if (($urandom % 5) == 0) h[3:0] = 4'hF;
            len = $urandom % 18;
            send_byte(h, len == 0, ($urandom % 8) != 0, "R1");
            for (int i = 0; i < len; i++)
                send_byte(8'($urandom), i == len - 1, ($urandom % 8) != 0, "R8");
            if (m_pending && ($urandom % 2)) service();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule